// File: doc/BRIEF.md
# PAL Chroma Phase Generator

This block produces the digital colour-subcarrier drive for a PAL composite video encoder. It runs from a clock at four times the colour subcarrier frequency. A Johnson ring divides that clock into two square waves at the subcarrier rate, a quarter period apart, which serve as the U and V references. The V reference is inverted on every other line. A toggle flip-flop flips it on each rising edge of horizontal sync.

For each 3-bit RGB pixel, a fixed steering table decides which of the two references are gated onto the chroma drive lines, and whether each is inverted. Black and white carry no chroma. Pixel chroma is blanked while sync is high. It also stays blanked during a counted burst window that opens as soon as sync ends. During that window both lines carry a fixed reference phase, which the receiver locks to. The drive lines are active-low NAND outputs that an external resistor network sums with luminance.

Three states control the window:
- ACTIVE: pixels are steered.
- SYNC: sync is held.
- BURST: the reference is sent for a counted number of clocks.

The transitions are:
- ACTIVE goes to SYNC when hsync is high.
- SYNC goes to BURST on the first clock with hsync low.
- BURST goes to ACTIVE when the count expires.
- BURST goes back to SYNC if hsync rises early.

Top module: `pal_chroma_gen`

## Requirements
- R1: While rst_n is low, with rgb at 000, the block outputs u_ref=0, v_ref=0, line_odd=0, u_gate=0, v_gate=0, burst_gate=0, u_drive_n=1 and v_drive_n=1.
- R2: u_ref is a square wave with a period of four clocks. Its values in the first four clocks after reset release are 0,1,1,0, and the pattern then repeats.
- R3: v_ref XOR line_odd equals the value u_ref had one clock earlier, so the V reference lags U by a quarter subcarrier period.
- R4: line_odd toggles at the first clock edge that samples hsync high, and at no other edge.
- R5: In ACTIVE, with hsync low, the steering depends on rgb = {R,G,B}:
  - red (100): gates both, inverts U.
  - cyan (011): gates both, inverts V.
  - green (010): gates both, inverts both.
  - magenta (101): gates both, inverts neither.
  - yellow (110): gates U only, inverted.
  - blue (001): gates U only, not inverted.
- R6: Each drive is the NAND of its gate and the steered phase: u_drive_n = !(u_gate & (u_ref ^ inv_u)), and likewise for V. A line whose gate is off sits at 1.
- R7: For rgb values 000 (black) and 111 (white), both gates are off.
- R8: Complementary colours (rgb and ~rgb, each neither black nor white) give opposite levels on every gated drive line in the same clock.
- R9: While hsync is high, both gates are off, whatever the rgb value.
- R10: burst_gate rises on the clock after the first edge that samples hsync low, and stays high for BURST_CYCLES clocks (default 89). While it is high and hsync is low, both gates are on, u_drive_n = u_ref and v_drive_n = !v_ref.
- R11: If hsync rises during a burst, the burst ends at that edge, pixel gates stay off, and a full-length burst follows the end of the new sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the subcarrier frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal sync, active high, synchronous to clk |
| rgb | input | 3 | Pixel colour {R,G,B} |
| u_ref | output | 1 | U subcarrier reference |
| v_ref | output | 1 | Line-alternated V subcarrier reference |
| line_odd | output | 1 | Line alternation state |
| u_gate | output | 1 | U drive enable |
| v_gate | output | 1 | V drive enable |
| u_drive_n | output | 1 | Active-low U chroma drive |
| v_drive_n | output | 1 | Active-low V chroma drive |
| burst_gate | output | 1 | High during the colour burst window |

## Verification
The assertions assume that hsync is synchronous to clk. They also assume that the period checks on u_ref have at least three clocks of history after reset, which the checker enforces with an age counter. The burst-length property assumes each sync pulse lasts at least one clock. The directed stimulus changes hsync and rgb only on falling clock edges and keeps every sync pulse two or more clocks wide. One scenario raises sync in the middle of a burst on purpose, to exercise the abort path, and the length checks allow for it.

// File: rtl/pal_chroma_pkg.sv
package pal_chroma_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_SYNC   = 2'd1,
        ST_BURST  = 2'd2
    } win_state_t;

    typedef struct packed {
        logic en_u;
        logic inv_u;
        logic en_v;
        logic inv_v;
    } steer_t;

    localparam steer_t STEER_OFF   = '{en_u: 1'b0, inv_u: 1'b0, en_v: 1'b0, inv_v: 1'b0};
    localparam steer_t STEER_BURST = '{en_u: 1'b1, inv_u: 1'b1, en_v: 1'b1, inv_v: 1'b0};

    // Colour {R,G,B} to phase selection; complements use inverted selections.
    function automatic steer_t colour_steer(input logic [2:0] rgb);
        steer_t s;
        s = STEER_OFF;
        unique case (rgb)
            3'b100: s = '{en_u: 1'b1, inv_u: 1'b1, en_v: 1'b1, inv_v: 1'b0};
            3'b011: s = '{en_u: 1'b1, inv_u: 1'b0, en_v: 1'b1, inv_v: 1'b1};
            3'b010: s = '{en_u: 1'b1, inv_u: 1'b1, en_v: 1'b1, inv_v: 1'b1};
            3'b101: s = '{en_u: 1'b1, inv_u: 1'b0, en_v: 1'b1, inv_v: 1'b0};
            3'b110: s = '{en_u: 1'b1, inv_u: 1'b1, en_v: 1'b0, inv_v: 1'b0};
            3'b001: s = '{en_u: 1'b1, inv_u: 1'b0, en_v: 1'b0, inv_v: 1'b0};
            default: s = STEER_OFF;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pal_subcarrier_ring.sv
module pal_subcarrier_ring #(
    parameter int RING_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic u_ph,
    output logic v_ph
);
    localparam int LAST = RING_STAGES - 1;

    logic [LAST:0] ring_q;

    // Johnson ring: period of 2*RING_STAGES clocks, adjacent taps one clock apart.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else begin
            ring_q <= {ring_q[LAST-1:0], ~ring_q[LAST]};
        end
    end

    assign u_ph = ring_q[0];
    assign v_ph = ring_q[1];

endmodule

// File: rtl/pal_line_toggle.sv
module pal_line_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync,
    output logic line_odd
);
    logic hsync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hsync_q  <= 1'b0;
            line_odd <= 1'b0;
        end else begin
            hsync_q <= hsync;
            if (hsync && !hsync_q) begin
                line_odd <= ~line_odd;
            end
        end
    end

endmodule

// File: rtl/pal_burst_window.sv
module pal_burst_window
    import pal_chroma_pkg::*;
#(
    parameter int BURST_CYCLES = 89
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync,
    output logic pix_ok,
    output logic in_burst
);
    localparam int CNT_W = (BURST_CYCLES > 1) ? $clog2(BURST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BURST_CYCLES - 1);

    win_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (hsync) state_d = ST_SYNC;
            end
            ST_SYNC: begin
                if (!hsync) begin
                    state_d = ST_BURST;
                    cnt_d   = '0;
                end
            end
            ST_BURST: begin
                if (hsync) begin
                    state_d = ST_SYNC;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = ST_ACTIVE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_ACTIVE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        pix_ok   = 1'b0;
        in_burst = 1'b0;
        unique case (state_q)
            ST_ACTIVE: pix_ok   = 1'b1;
            ST_SYNC:   pix_ok   = 1'b0;
            ST_BURST:  in_burst = 1'b1;
            default:   pix_ok   = 1'b0;
        endcase
    end

endmodule

// File: rtl/pal_phase_steer.sv
module pal_phase_steer
    import pal_chroma_pkg::*;
(
    input  logic       u_ph,
    input  logic       v_ph,
    input  logic [2:0] rgb,
    input  logic       hsync,
    input  logic       pix_ok,
    input  logic       in_burst,
    output logic       u_gate,
    output logic       v_gate,
    output logic       u_drive_n,
    output logic       v_drive_n
);
    steer_t sel;

    always_comb begin
        if (hsync) begin
            sel = STEER_OFF;
        end else if (in_burst) begin
            sel = STEER_BURST;
        end else if (pix_ok) begin
            sel = colour_steer(rgb);
        end else begin
            sel = STEER_OFF;
        end
    end

    assign u_gate    = sel.en_u;
    assign v_gate    = sel.en_v;
    assign u_drive_n = ~(sel.en_u & (u_ph ^ sel.inv_u));
    assign v_drive_n = ~(sel.en_v & (v_ph ^ sel.inv_v));

endmodule

// File: rtl/pal_chroma_gen.sv
module pal_chroma_gen #(
    parameter int RING_STAGES  = 2,
    parameter int BURST_CYCLES = 89
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hsync,
    input  logic [2:0] rgb,
    output logic       u_ref,
    output logic       v_ref,
    output logic       line_odd,
    output logic       u_gate,
    output logic       v_gate,
    output logic       u_drive_n,
    output logic       v_drive_n,
    output logic       burst_gate
);
    logic u_ph, v_raw, pix_ok, in_burst;

    pal_subcarrier_ring #(.RING_STAGES(RING_STAGES)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .u_ph  (u_ph),
        .v_ph  (v_raw)
    );

    pal_line_toggle u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .hsync    (hsync),
        .line_odd (line_odd)
    );

    pal_burst_window #(.BURST_CYCLES(BURST_CYCLES)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .hsync    (hsync),
        .pix_ok   (pix_ok),
        .in_burst (in_burst)
    );

    assign u_ref      = u_ph;
    assign v_ref      = v_raw ^ line_odd;
    assign burst_gate = in_burst;

    pal_phase_steer u_steer (
        .u_ph      (u_ref),
        .v_ph      (v_ref),
        .rgb       (rgb),
        .hsync     (hsync),
        .pix_ok    (pix_ok),
        .in_burst  (in_burst),
        .u_gate    (u_gate),
        .v_gate    (v_gate),
        .u_drive_n (u_drive_n),
        .v_drive_n (v_drive_n)
    );

endmodule

// File: rtl/pal_chroma_checker.sv
module pal_chroma_checker #(
    parameter int BURST_CYCLES = 89
) (
    input logic clk,
    input logic rst_n,
    input logic hsync,
    input logic u_ref,
    input logic v_ref,
    input logic line_odd,
    input logic u_gate,
    input logic v_gate,
    input logic u_drive_n,
    input logic v_drive_n,
    input logic burst_gate
);
    localparam int RUN_W = $clog2(BURST_CYCLES + 2);

    logic [1:0]       age;
    logic [RUN_W-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
            run <= '0;
        end else begin
            if (age != 2'd3) age <= age + 1'b1;
            run <= burst_gate ? run + 1'b1 : '0;
        end
    end

    a_r2_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> (u_ref != $past(u_ref, 2)));

    a_r3_quadrature: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> ((v_ref ^ line_odd) == $past(u_ref)));

    a_r4_line_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> ((line_odd != $past(line_odd)) == ($past(hsync) && !$past(hsync, 2))));

    a_r6_idle_u: assert property (@(posedge clk) disable iff (!rst_n)
        !u_gate |-> u_drive_n);

    a_r6_idle_v: assert property (@(posedge clk) disable iff (!rst_n)
        !v_gate |-> v_drive_n);

    a_r9_blank_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |-> (!u_gate && !v_gate));

    a_r10_burst_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_gate && !hsync) |-> (u_gate && v_gate && (u_drive_n == u_ref) && (v_drive_n == !v_ref)));

    a_r10_burst_start: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $rose(burst_gate)) |-> (!$past(hsync) && $past(hsync, 2)));

    a_r10_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
        burst_gate |-> (run < RUN_W'(BURST_CYCLES)));

    a_r10_burst_full: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $fell(burst_gate) && !$past(hsync)) |-> (run == RUN_W'(BURST_CYCLES)));

endmodule

bind pal_chroma_gen pal_chroma_checker #(.BURST_CYCLES(BURST_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hsync      (hsync),
    .u_ref      (u_ref),
    .v_ref      (v_ref),
    .line_odd   (line_odd),
    .u_gate     (u_gate),
    .v_gate     (v_gate),
    .u_drive_n  (u_drive_n),
    .v_drive_n  (v_drive_n),
    .burst_gate (burst_gate)
);

// File: tb/pal_chroma_gen_test.sv
`timescale 1ns/100ps
module pal_chroma_gen_test;
    localparam int BC = 89;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync = 1'b0;
    logic [2:0] rgb = 3'b000;
    logic u_ref, v_ref, line_odd, u_gate, v_gate, u_drive_n, v_drive_n, burst_gate;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pal_chroma_gen #(.RING_STAGES(2), .BURST_CYCLES(BC)) uut (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .rgb(rgb),
        .u_ref(u_ref), .v_ref(v_ref), .line_odd(line_odd),
        .u_gate(u_gate), .v_gate(v_gate),
        .u_drive_n(u_drive_n), .v_drive_n(v_drive_n), .burst_gate(burst_gate)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected steering {en_u, inv_u, en_v, inv_v} from the R5 table.
    function automatic logic [3:0] exp_sel(input logic [2:0] c);
        case (c)
            3'b100: return 4'b1110;
            3'b011: return 4'b1011;
            3'b010: return 4'b1111;
            3'b101: return 4'b1010;
            3'b110: return 4'b1100;
            3'b001: return 4'b1000;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; hsync = 1'b0; rgb = 3'b000;
        repeat (3) step();
        chk("R1 u_ref", u_ref, 0);
        chk("R1 v_ref", v_ref, 0);
        chk("R1 line_odd", line_odd, 0);
        chk("R1 gates", {u_gate, v_gate}, 0);
        chk("R1 drives", {u_drive_n, v_drive_n}, 3);
        chk("R1 burst_gate", burst_gate, 0);
    endtask

    task automatic t_phase();
        logic prev_u;
        logic [3:0] seq_u = 4'b0110;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        prev_u = u_ref;
        chk("R2 u_ref cycle0", u_ref, 0);
        for (int i = 1; i < 12; i++) begin
            step();
            chk("R2 u_ref pattern", u_ref, seq_u[3 - (i % 4)]);
            chk("R3 v lags u", v_ref ^ line_odd, prev_u);
            prev_u = u_ref;
        end
    endtask

    task automatic t_colours();
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 4; k++) begin
                logic [3:0] s;
                @(negedge clk);
                rgb = 3'(c);
                #1;
                s = exp_sel(3'(c));
                if (c == 0 || c == 7) chk("R7 no chroma", {u_gate, v_gate}, 0);
                chk("R5 gates", {u_gate, v_gate}, {s[3], s[1]});
                chk("R6 u drive", u_drive_n, !(s[3] & (u_ref ^ s[2])));
                chk("R6 v drive", v_drive_n, !(s[1] & (v_ref ^ s[0])));
            end
        end
    endtask

    task automatic t_complement();
        for (int c = 1; c < 7; c++) begin
            for (int k = 0; k < 4; k++) begin
                logic du, dv;
                @(negedge clk);
                rgb = 3'(c);
                #0.5;
                du = u_drive_n; dv = v_drive_n;
                rgb = ~3'(c);
                #0.5;
                chk("R8 complement u", u_drive_n, !du);
                if (v_gate) chk("R8 complement v", v_drive_n, !dv);
            end
        end
    endtask

    task automatic t_sync_burst();
        logic l0;
        logic prev_u;
        rgb = 3'b100;
        step();
        l0 = line_odd;
        @(negedge clk);
        hsync = 1'b1;
        #1;
        chk("R9 blank at sync", {u_gate, v_gate}, 0);
        chk("R4 no flip before edge", line_odd, l0);
        step();
        chk("R4 flip on sync", line_odd, !l0);
        step();
        chk("R4 single flip", line_odd, !l0);
        chk("R9 blank in sync", {u_gate, v_gate}, 0);
        @(negedge clk);
        hsync = 1'b0;
        #1;
        chk("R10 burst not yet", burst_gate, 0);
        chk("R10 gates off pre-burst", {u_gate, v_gate}, 0);
        prev_u = u_ref;
        for (int i = 0; i < BC; i++) begin
            step();
            chk("R10 burst high", burst_gate, 1);
            chk("R10 burst gates", {u_gate, v_gate}, 3);
            chk("R10 burst u phase", u_drive_n, u_ref);
            chk("R10 burst v phase", v_drive_n, !v_ref);
            chk("R3 v lags u in burst", v_ref ^ line_odd, prev_u);
            prev_u = u_ref;
        end
        step();
        chk("R10 burst ends", burst_gate, 0);
        chk("R5 red after burst", {u_gate, v_gate}, 3);
    endtask

    task automatic t_abort();
        int len;
        rgb = 3'b010;
        @(negedge clk); hsync = 1'b1;
        step();
        @(negedge clk); hsync = 1'b0;
        #1;
        repeat (11) step();
        chk("R11 in burst", burst_gate, 1);
        @(negedge clk); hsync = 1'b1;
        #1;
        chk("R11 gates off on early sync", {u_gate, v_gate}, 0);
        step();
        chk("R11 burst aborted", burst_gate, 0);
        chk("R11 pixels still blanked", {u_gate, v_gate}, 0);
        @(negedge clk); hsync = 1'b0;
        #1;
        len = 0;
        step();
        while (burst_gate && len < 300) begin
            len++;
            step();
        end
        chk("R11 full burst after abort", len, BC);
    endtask

    initial begin
        t_reset();
        t_phase();
        t_colours();
        t_complement();
        t_sync_burst();
        t_abort();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule